// File: doc/BRIEF.md
# Four-Phase Interleaved Carrier PWM Modulator

This block drives the four switches of a five-level step-down power stage. It uses phase-shifted carrier modulation. A single phase counter runs over one switching period. From it the block folds four up-down triangular carriers of equal period, spaced a quarter period apart. Each carrier is compared with the effective duty of its own switch, so there is one carrier per switch. Because the four carriers are interleaved, the combined switched node toggles at four times the switching rate.

Each switch's duty starts from a common command. Signed balancing corrections are then applied. Switch 1 adds the first correction, switch 3 subtracts it, switch 2 adds the second and switch 4 adds the third. Each result is clipped to the legal range. The modulator takes all duties, the period setting and the region code together, only when carrier 1 sits at its valley. This way the four legs never see a change in the middle of a period. A region code tells the controller which quarter of the duty range the common command lies in. An enable input blanks all gates without disturbing the carrier timing.

Top module: `pwm4_interleave`

## Requirements
- R1: While rst_ni is low, gate_o is 0 and region_o is 0, and the phase counter restarts at 0 with a half period of 1.
- R2: With a latched half period H, the switching period is 4·H clocks. The phase counter p runs 0..4H−1. Carrier k (k=0..3, driving gate_o[k]) has phase q=(p+k·H) mod 4H and value c=q for q≤2H, otherwise c=4H−q. This places the carriers 0, 1/4, 1/2 and 3/4 period apart, with peak 2H.
- R3: The effective duties are: D0=duty_i+bal1_i, D1=duty_i+bal2_i, D2=duty_i−bal1_i, D3=duty_i+bal4_i. duty_i is an unsigned 12-bit fraction whose full scale is 4095. The bal inputs are signed 12-bit two's complement.
- R4: Each effective duty is clipped to 0..4095 after the correction is applied, with no wrap-around. A clipped 0 keeps its gate low.
- R5: duty_i, bal1_i, bal2_i, bal4_i and half_per_i are sampled only at the edge where the phase counter goes from 4H−1 to 0. Changes at any other time have no effect until then.
- R6: gate_o[k] updates one clock after the carrier value it uses. It goes high when en_i=1 and either Dk=4095 or Dk·2H > c·4095.
- R7: region_o holds duty_i[11:10], sampled at the same edge as R5. The codes are: 0 for below 1/4, 1 for 1/4 up to but not including 1/2, 2 for 1/2 up to but not including 3/4, and 3 for 3/4 and above.
- R8: When en_i is 0, every gate is low on the next clock. The phase counter keeps running, so gating resumes in phase once en_i returns to 1.
- R9: A half_per_i of 0 is latched as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Gate enable |
| half_per_i | input | HALF_W (10) | Quarter of the switching period in clocks |
| duty_i | input | DUTY_W (12) | Common duty command, unsigned fraction |
| bal1_i | input | DUTY_W (12) | Signed correction: added to switch 1, subtracted from switch 3 |
| bal2_i | input | DUTY_W (12) | Signed correction for switch 2 |
| bal4_i | input | DUTY_W (12) | Signed correction for switch 4 |
| gate_o | output | 4 | Gate signals, bit k drives switch k+1 |
| region_o | output | 2 | Region code of the latched common duty |

## Verification
Two functions can meet on the same edge. At the valley of carrier 1, a new period, new duties and a new region code are all taken at once. On that same edge a change of enable, or a saturating correction, can also land. The bench moves its inputs at arbitrary points in the period, including periods whose length it has just changed. It compares every output cycle against a cycle model built from R2–R9. It also counts gate high time over whole periods against values worked out by hand for the chosen duties.

// File: rtl/pwm4_pkg.sv
package pwm4_pkg;
  localparam int NUM_LEGS = 4;

  typedef enum logic [1:0] {
    REG_LOW  = 2'd0,
    REG_MIDL = 2'd1,
    REG_MIDH = 2'd2,
    REG_HIGH = 2'd3
  } region_e;
endpackage

// File: rtl/pwm4_phase_ctr.sv
module pwm4_phase_ctr #(
  parameter int HALF_W = 10,
  localparam int M_W   = HALF_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HALF_W-1:0] half_per_i,
  output logic [M_W-1:0]    phase_o,
  output logic [HALF_W-1:0] half_o,
  output logic              wrap_o
);
  logic [M_W-1:0]    phase_q;
  logic [HALF_W-1:0] half_q;
  logic [M_W-1:0]    last_w;
  logic [HALF_W-1:0] half_nxt;

  assign last_w   = M_W'({half_q, 2'b00}) - M_W'(1);
  assign wrap_o   = (phase_q == last_w);
  assign half_nxt = (half_per_i == '0) ? HALF_W'(1) : half_per_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      half_q  <= HALF_W'(1);
    end else if (wrap_o) begin
      phase_q <= '0;
      half_q  <= half_nxt;
    end else begin
      phase_q <= phase_q + M_W'(1);
    end
  end

  assign phase_o = phase_q;
  assign half_o  = half_q;
endmodule

// File: rtl/pwm4_duty_bank.sv
module pwm4_duty_bank
  import pwm4_pkg::*;
#(
  parameter int DUTY_W = 12
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wrap_i,
  input  logic [DUTY_W-1:0]              duty_i,
  input  logic [DUTY_W-1:0]              bal1_i,
  input  logic [DUTY_W-1:0]              bal2_i,
  input  logic [DUTY_W-1:0]              bal4_i,
  output logic [NUM_LEGS-1:0][DUTY_W-1:0] duty_o,
  output logic [1:0]                     region_o
);
  localparam int S_W = DUTY_W + 2;
  localparam logic signed [S_W-1:0] FS_S = S_W'({DUTY_W{1'b1}});

  logic signed [S_W-1:0] base_w, e1_w, e2_w, e4_w;
  logic signed [S_W-1:0] sum_w [NUM_LEGS];
  logic [NUM_LEGS-1:0][DUTY_W-1:0] duty_q;
  region_e region_q;

  function automatic logic [DUTY_W-1:0] clip(input logic signed [S_W-1:0] v);
    if (v[S_W-1])   return '0;
    else if (v > FS_S) return '1;
    else            return v[DUTY_W-1:0];
  endfunction

  assign base_w = {2'b00, duty_i};
  assign e1_w   = {{2{bal1_i[DUTY_W-1]}}, bal1_i};
  assign e2_w   = {{2{bal2_i[DUTY_W-1]}}, bal2_i};
  assign e4_w   = {{2{bal4_i[DUTY_W-1]}}, bal4_i};

  // leg order matters: leg 2 takes the mirrored first correction
  always_comb begin
    sum_w[0] = base_w + e1_w;
    sum_w[1] = base_w + e2_w;
    sum_w[2] = base_w - e1_w;
    sum_w[3] = base_w + e4_w;
  end

  for (genvar k = 0; k < NUM_LEGS; k++) begin : g_leg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     duty_q[k] <= '0;
      else if (wrap_i) duty_q[k] <= clip(sum_w[k]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     region_q <= REG_LOW;
    else if (wrap_i) region_q <= region_e'(duty_i[DUTY_W-1 -: 2]);
  end

  assign duty_o   = duty_q;
  assign region_o = region_q;
endmodule

// File: rtl/pwm4_leg.sv
module pwm4_leg #(
  parameter int DUTY_W = 12,
  parameter int HALF_W = 10,
  parameter int PHASE  = 0,
  localparam int M_W   = HALF_W + 2,
  localparam int W1    = M_W + 1,
  localparam int C_W   = HALF_W + 1,
  localparam int P_W   = DUTY_W + C_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [M_W-1:0]    phase_i,
  input  logic [HALF_W-1:0] half_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic              gate_o
);
  localparam logic [DUTY_W-1:0] FS = '1;

  logic [W1-1:0]  h_x, per_x, peak_x, ph_sum, ph_w;
  logic [C_W-1:0] car_w;
  logic [P_W-1:0] lhs_w, rhs_w;
  logic           hit_w, gate_q;

  assign h_x    = W1'(half_i);
  assign per_x  = h_x << 2;
  assign peak_x = h_x << 1;
  assign ph_sum = W1'(phase_i) + h_x * W1'(PHASE);
  assign ph_w   = (ph_sum >= per_x) ? ph_sum - per_x : ph_sum;
  // fold the sawtooth phase into a triangle peaking at 2H
  assign car_w  = (ph_w <= peak_x) ? C_W'(ph_w) : C_W'(per_x - ph_w);

  assign lhs_w  = P_W'(duty_i) * P_W'(peak_x);
  assign rhs_w  = P_W'(car_w) * P_W'(FS);
  assign hit_w  = (duty_i == FS) || (lhs_w > rhs_w);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= en_i & hit_w;
  end

  assign gate_o = gate_q;
endmodule

// File: rtl/pwm4_interleave.sv
module pwm4_interleave
  import pwm4_pkg::*;
#(
  parameter int DUTY_W = 12,
  parameter int HALF_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [HALF_W-1:0] half_per_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic [DUTY_W-1:0] bal1_i,
  input  logic [DUTY_W-1:0] bal2_i,
  input  logic [DUTY_W-1:0] bal4_i,
  output logic [3:0]        gate_o,
  output logic [1:0]        region_o
);
  localparam int M_W = HALF_W + 2;

  logic [M_W-1:0]                    phase_w;
  logic [HALF_W-1:0]                 half_w;
  logic                              wrap_w;
  logic [NUM_LEGS-1:0][DUTY_W-1:0]   duty_eff;

  pwm4_phase_ctr #(.HALF_W(HALF_W)) i_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .half_per_i (half_per_i),
    .phase_o    (phase_w),
    .half_o     (half_w),
    .wrap_o     (wrap_w)
  );

  pwm4_duty_bank #(.DUTY_W(DUTY_W)) i_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wrap_i   (wrap_w),
    .duty_i   (duty_i),
    .bal1_i   (bal1_i),
    .bal2_i   (bal2_i),
    .bal4_i   (bal4_i),
    .duty_o   (duty_eff),
    .region_o (region_o)
  );

  for (genvar k = 0; k < NUM_LEGS; k++) begin : g_leg
    pwm4_leg #(.DUTY_W(DUTY_W), .HALF_W(HALF_W), .PHASE(k)) i_leg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (en_i),
      .phase_i (phase_w),
      .half_i  (half_w),
      .duty_i  (duty_eff[k]),
      .gate_o  (gate_o[k])
    );
  end
endmodule

// File: rtl/pwm4_interleave_chk.sv
module pwm4_interleave_chk #(
  parameter int DUTY_W = 12,
  parameter int HALF_W = 10,
  localparam int M_W   = HALF_W + 2
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   en_i,
  input logic [3:0]             gate_i,
  input logic [1:0]             region_i,
  input logic [M_W-1:0]         phase_i,
  input logic [HALF_W-1:0]      half_i,
  input logic [3:0][DUTY_W-1:0] duty_i
);
  localparam logic [DUTY_W-1:0] FS = '1;

  p_gate_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (gate_i == 4'b0000));

  p_duty_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i != '0) |-> $stable(duty_i));

  p_region_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i != '0) |-> $stable(region_i));

  p_half_nz_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_i != '0);

  p_phase_rng_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_i < M_W'({half_i, 2'b00}));

  for (genvar k = 0; k < 4; k++) begin : g_leg
    p_full_on_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && duty_i[k] == FS) |=> gate_i[k]);
    p_zero_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (duty_i[k] == '0) |=> !gate_i[k]);
  end
endmodule

bind pwm4_interleave pwm4_interleave_chk #(.DUTY_W(DUTY_W), .HALF_W(HALF_W)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .gate_i   (gate_o),
  .region_i (region_o),
  .phase_i  (phase_w),
  .half_i   (half_w),
  .duty_i   (duty_eff)
);

// File: tb/test_pwm4_interleave.sv
module test_pwm4_interleave;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               en = 1'b0;
  logic [9:0]         half_per = 10'd8;
  logic [11:0]        duty = '0;
  logic signed [11:0] bal1 = '0, bal2 = '0, bal4 = '0;
  logic [3:0]         gate;
  logic [1:0]         region;

  int chk_cnt = 0;
  int fail_cnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwm4_interleave i_pwm4_interleave (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .half_per_i(half_per),
    .duty_i(duty), .bal1_i(bal1), .bal2_i(bal2), .bal4_i(bal4),
    .gate_o(gate), .region_o(region)
  );

  // cycle model from the requirements
  int ms = 0, hs = 1;
  int ds [4] = '{0, 0, 0, 0};
  logic [3:0] exp_g = '0;
  logic [1:0] exp_r = '0;

  function automatic int clampd(input int v);
    return (v < 0) ? 0 : ((v > 4095) ? 4095 : v);
  endfunction

  always @(posedge clk) begin : model
    if (!rst_n) begin
      ms = 0; hs = 1; ds = '{0, 0, 0, 0}; exp_g = '0; exp_r = '0;
    end else begin
      logic [3:0] eg;
      for (int k = 0; k < 4; k++) begin
        int ph, c;
        ph = (ms + k * hs) % (4 * hs);
        c  = (ph <= 2 * hs) ? ph : 4 * hs - ph;
        eg[k] = en && (ds[k] == 4095 || ds[k] * 2 * hs > c * 4095);
      end
      if (ms == 4 * hs - 1) begin
        ms = 0;
        hs = (half_per == 0) ? 1 : int'(half_per);
        ds[0] = clampd(int'(duty) + int'(bal1));
        ds[1] = clampd(int'(duty) + int'(bal2));
        ds[2] = clampd(int'(duty) - int'(bal1));
        ds[3] = clampd(int'(duty) + int'(bal4));
        exp_r = duty[11:10];
      end else begin
        ms = ms + 1;
      end
      exp_g = eg;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    chk_cnt++;
    if (act != exp) begin
      fail_cnt++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_cmp(input int n, input string req);
    repeat (n) begin
      @(negedge clk);
      chk({req, " gates"}, int'(gate), int'(exp_g));
      chk({req, " region"}, int'(region), int'(exp_r));
    end
  endtask

  task automatic count_high(input int k, input int n, output int cnt);
    cnt = 0;
    repeat (n) begin
      @(negedge clk);
      cnt += int'(gate[k]);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 gates low in reset", int'(gate), 0);
    chk("R1 region zero in reset", int'(region), 0);
    en = 1'b1;
    rst_n = 1'b1;
    run_cmp(8, "R1 restart phase");
  endtask

  task automatic t_basic;
    int n;
    half_per = 10'd8; duty = 12'd1500; bal1 = '0; bal2 = '0; bal4 = '0;
    run_cmp(96, "R2 R6 basic");
    for (int k = 0; k < 4; k++) begin
      count_high(k, 32, n);
      chk($sformatf("R6 equal duty high count leg%0d", k), n, 11);
    end
  endtask

  task automatic t_bal;
    int n;
    bal1 = 12'(300); bal2 = 12'(-200); bal4 = 12'(700);
    run_cmp(96, "R3 balancing");
    count_high(0, 32, n); chk("R3 leg0 d+b1", n, 15);
    count_high(1, 32, n); chk("R3 leg1 d+b2", n, 11);
    count_high(2, 32, n); chk("R3 leg2 d-b1", n, 9);
    count_high(3, 32, n); chk("R3 leg3 d+b4", n, 17);
  endtask

  task automatic t_sat;
    int n;
    duty = 12'd4000; bal1 = 12'(500); bal2 = '0; bal4 = 12'(-2048);
    run_cmp(96, "R4 saturate high");
    count_high(0, 32, n); chk("R4 leg0 clipped full", n, 32);
    count_high(2, 32, n); chk("R4 leg2", n, 27);
    count_high(3, 32, n); chk("R4 leg3", n, 15);
    duty = 12'd100; bal1 = 12'(500); bal2 = 12'(-2048); bal4 = 12'(2047);
    run_cmp(96, "R4 saturate low");
    count_high(2, 32, n); chk("R4 leg2 clipped zero", n, 0);
    count_high(1, 32, n); chk("R4 leg1 clipped zero", n, 0);
    count_high(0, 32, n); chk("R4 leg0", n, 5);
    count_high(3, 32, n); chk("R4 leg3", n, 17);
  endtask

  task automatic t_latch;
    duty = '0; bal1 = '0; bal2 = '0; bal4 = '0;
    run_cmp(70, "R5 settle");
    repeat (11) @(negedge clk);
    duty = 12'd4095;
    run_cmp(5, "R5 mid-period change");
    duty = 12'd1000;
    run_cmp(40, "R5 second change");
    repeat (7) @(negedge clk);
    half_per = 10'd5;
    run_cmp(64, "R5 period latch");
    half_per = 10'd8;
    run_cmp(64, "R5 period back");
  endtask

  task automatic t_region;
    int vals [7] = '{1023, 1024, 2047, 2048, 3071, 3072, 4095};
    int regs [7] = '{0, 1, 1, 2, 2, 3, 3};
    bal1 = '0; bal2 = '0; bal4 = '0;
    for (int i = 0; i < 7; i++) begin
      duty = 12'(vals[i]);
      run_cmp(70, "R7 region");
      chk($sformatf("R7 region for duty %0d", vals[i]), int'(region), regs[i]);
    end
  endtask

  task automatic t_enable;
    duty = 12'd2000;
    run_cmp(40, "R8 enabled");
    en = 1'b0;
    @(negedge clk);
    repeat (40) begin
      @(negedge clk);
      chk("R8 gates blanked", int'(gate), 0);
    end
    en = 1'b1;
    run_cmp(70, "R8 resume in phase");
  endtask

  task automatic t_half0;
    int n;
    half_per = 10'd0; duty = 12'd2048;
    run_cmp(64, "R9 half zero");
    count_high(0, 40, n);
    chk("R9 period of four clocks", n, 30);
    half_per = 10'd3;
    run_cmp(48, "R2 half three");
    half_per = 10'd100; duty = 12'd777; bal1 = 12'(-90); bal4 = 12'(33);
    run_cmp(900, "R2 long period");
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk_cnt++;
      fail_cnt++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", chk_cnt, fail_cnt);
      $finish;
    end
  end

  initial begin : main
    t_reset();
    t_basic();
    t_bal();
    t_sat();
    t_latch();
    t_region();
    t_enable();
    t_half0();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", chk_cnt, fail_cnt);
    $finish;
  end
endmodule